// File: doc/BRIEF.md
# Multi-Digit Decimal (Packed BCD) Adder

This block adds two unsigned decimal numbers held in packed BCD form, together with a single carry-in bit. Each operand holds `DIGITS` decimal digits (four by default), four bits per digit. The units digit sits in the lowest nibble. The adder is built as a chain of identical digit cells. Each cell first adds its two digits and the incoming carry in plain binary, which gives a value from 0 to 19. A small correction stage then turns that binary value back into one decimal digit and a decimal carry, and that carry feeds the binary adder of the next more significant cell.

The carry out of the top cell is a half-digit that can only be 0 or 1, so with the default size the result spans 00000 to 19999. The digit sum and the top carry are captured in output registers on the rising clock edge. A synchronous active-high reset clears both. The block is meant for counters, totalizers and display paths that keep their values in decimal. Operand nibbles above 9 are outside its contract.

Top module: `bcd_chain_adder`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `sum_out` = 0 and `carry_out` = 0.
- R2: The outputs have a latency of exactly one clock. The operands and carry-in present at a rising edge appear on `sum_out`/`carry_out` after that edge and stay stable until the following edge.
- R3: Digit k (k = 0 is the units digit) occupies bits [4k+3:4k] of `a_in`, `b_in` and `sum_out`, so the nibbles rise in significance from the bottom.
- R4: When a digit cell's binary total (digit a + digit b + incoming carry) is 0 to 9, the output digit equals that total and the cell passes carry 0 upward.
- R5: When a digit cell's binary total is 10 to 19, the output digit equals the total minus 10 and the cell passes carry 1 upward.
- R6: Each cell's decimal carry enters the next cell's addition, so a carry can ripple through a run of 9 digits (for example 0999 + 0001 = 1000). `carry_out` is the decimal carry of the top digit: it is 1 whenever the two top digits sum to 10 or more, and 0 whenever they sum to 8 or less.
- R7: `carry_in` adds one unit to the units digit.
- R8: For valid digit inputs, `{carry_out, sum_out}` read as decimal equals a + b + `carry_in`. The largest case is 9999 + 9999 + 1 = 1 9999.
- R9: For valid digit inputs, every nibble of `sum_out` is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 4*DIGITS | First packed BCD operand, units digit in bits [3:0] |
| b_in | input | 4*DIGITS | Second packed BCD operand, units digit in bits [3:0] |
| carry_in | input | 1 | Decimal carry into the units digit |
| sum_out | output | 4*DIGITS | Registered packed BCD sum |
| carry_out | output | 1 | Registered half-digit carry from the top digit |

## Verification
Every output is one register away from a purely combinational cell chain. A wrong correction or carry decision therefore shows up one clock after the offending operands. It appears either as a nibble of 10 to 15, or as a digit that is off by six or by ten. A broken carry link shows only when a carry has to cross that digit boundary. For that reason the stimulus includes long runs of nines, totals that land exactly on 9 and on 10, and the all-nines-plus-carry extreme, alongside random valid operands.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;
  localparam int unsigned NIBBLE_W  = 4;
  localparam int unsigned DIGIT_MAX = 9;
  typedef logic [NIBBLE_W-1:0] bcd_digit_t;
endpackage

// File: rtl/bcd_ripple_add.sv
// Plain ripple-carry binary adder with carry out.
module bcd_ripple_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;

  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end

  assign co = c[W];
endmodule

// File: rtl/bcd_trim_add.sv
// Ripple adder whose final carry is never formed (modulo 2^W sum).
module bcd_trim_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s
);
  logic [W-1:0] c;

  assign c[0] = ci;

  for (genvar i = 0; i + 1 < W; i++) begin : g_carry
    assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end

  assign s = x ^ y ^ c;
endmodule

// File: rtl/bcd_digit_cell.sv
// One decimal digit: binary add, then decimal correction.
module bcd_digit_cell
  import bcd_adder_pkg::*;
(
  input  bcd_digit_t a_dig,
  input  bcd_digit_t b_dig,
  input  logic       c_in,
  output bcd_digit_t s_dig,
  output logic       c_out
);
  bcd_digit_t raw_sum;
  logic       raw_co;
  logic       dec_carry;
  bcd_digit_t fix_val;

  bcd_ripple_add #(.W(NIBBLE_W)) i_bin (
    .x  (a_dig),
    .y  (b_dig),
    .ci (c_in),
    .s  (raw_sum),
    .co (raw_co)
  );

  // Totals 16..19 show as binary carry; 10..15 as bit3 with bit2 or bit1.
  assign dec_carry = raw_co | (raw_sum[3] & raw_sum[2]) | (raw_sum[3] & raw_sum[1]);

  // Add six (0110) when a decimal carry leaves the digit, else zero.
  assign fix_val = {1'b0, dec_carry, dec_carry, 1'b0};

  bcd_trim_add #(.W(NIBBLE_W)) i_fix (
    .x  (fix_val),
    .y  (raw_sum),
    .ci (1'b0),
    .s  (s_dig)
  );

  assign c_out = dec_carry;
endmodule

// File: rtl/bcd_chain_adder.sv
module bcd_chain_adder
  import bcd_adder_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NIBBLE_W*DIGITS-1:0]   a_in,
  input  logic [NIBBLE_W*DIGITS-1:0]   b_in,
  input  logic                         carry_in,
  output logic [NIBBLE_W*DIGITS-1:0]   sum_out,
  output logic                         carry_out
);
  localparam int unsigned BUS_W = NIBBLE_W * DIGITS;

  logic [DIGITS:0]  link;
  logic [BUS_W-1:0] sum_comb;

  assign link[0] = carry_in;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcd_digit_cell i_cell (
      .a_dig (a_in[d*NIBBLE_W +: NIBBLE_W]),
      .b_dig (b_in[d*NIBBLE_W +: NIBBLE_W]),
      .c_in  (link[d]),
      .s_dig (sum_comb[d*NIBBLE_W +: NIBBLE_W]),
      .c_out (link[d+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out   <= '0;
      carry_out <= 1'b0;
    end else begin
      sum_out   <= sum_comb;
      carry_out <= link[DIGITS];
    end
  end
endmodule

// File: rtl/bcd_chain_adder_chk.sv
module bcd_chain_adder_chk
  import bcd_adder_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NIBBLE_W*DIGITS-1:0] a_in,
  input logic [NIBBLE_W*DIGITS-1:0] b_in,
  input logic                       carry_in,
  input logic [NIBBLE_W*DIGITS-1:0] sum_out,
  input logic                       carry_out
);
  localparam int unsigned TOP = (DIGITS - 1) * NIBBLE_W;

  logic       ops_ok;
  logic [4:0] top_pair;

  always_comb begin
    ops_ok = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (a_in[d*NIBBLE_W +: NIBBLE_W] > 4'd9 || b_in[d*NIBBLE_W +: NIBBLE_W] > 4'd9)
        ops_ok = 1'b0;
    end
  end

  assign top_pair = {1'b0, a_in[TOP +: NIBBLE_W]} + {1'b0, b_in[TOP +: NIBBLE_W]};

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_out == '0 && !carry_out));

  // R2
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_in == '0 && b_in == '0 && !carry_in))
      |-> (sum_out == '0 && !carry_out));

  // R7
  unit_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_in == '0 && b_in == '0 && carry_in))
      |-> (sum_out == {{(NIBBLE_W*DIGITS-1){1'b0}}, 1'b1} && !carry_out));

  // R6
  top_carry_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ops_ok && top_pair >= 5'd10)) |-> carry_out);

  // R6
  top_carry_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ops_ok && top_pair <= 5'd8)) |-> !carry_out);

  for (genvar d = 0; d < DIGITS; d++) begin : g_range
    // R9
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ops_ok)) |-> (sum_out[d*NIBBLE_W +: NIBBLE_W] <= 4'd9));
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(a_in) && $stable(b_in) && $stable(carry_in)
       && $past($stable(a_in) && $stable(b_in) && $stable(carry_in)))
      |=> ($stable(sum_out) && $stable(carry_out)));
endmodule

bind bcd_chain_adder bcd_chain_adder_chk #(.DIGITS(DIGITS)) i_chk (.*);

// File: tb/test_bcd_chain_adder.sv
`timescale 1ns/1ps
module test_bcd_chain_adder;
  localparam int DIGITS = 4;
  localparam int W      = 4 * DIGITS;
  localparam int LIMIT  = 10 ** DIGITS;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum_out;
  logic         carry_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bcd_chain_adder #(.DIGITS(DIGITS)) i_bcd_chain_adder (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .carry_in(carry_in), .sum_out(sum_out), .carry_out(carry_out)
  );

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    int t = v;
    for (int d = 0; d < DIGITS; d++) begin
      r[d*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic expect_eq(input string req, input logic [W:0] act, input logic [W:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_add(input string req, input int a, input int b, input bit ci);
    int total;
    @(negedge clk);
    a_in = to_bcd(a); b_in = to_bcd(b); carry_in = ci;
    @(negedge clk);
    total = a + b + int'(ci);
    expect_eq(req, {carry_out, sum_out}, {total >= LIMIT, to_bcd(total % LIMIT)});
    tests++;
    for (int d = 0; d < DIGITS; d++) begin
      if (sum_out[d*4 +: 4] > 4'd9) begin
        fails++;
        $display("FAIL R9: digit %0d actual %h expected <=9", d, sum_out[d*4 +: 4]);
        break;
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_eq("R1", {carry_out, sum_out}, '0);
    // R1: reset wins over nonzero inputs
    a_in = to_bcd(4321); b_in = to_bcd(1234);
    @(negedge clk);
    expect_eq("R1", {carry_out, sum_out}, '0);
    rst = 1'b0;
    @(negedge clk);
    // R2: one cycle after release the sum shows
    expect_eq("R2", {carry_out, sum_out}, {1'b0, to_bcd(5555)});
    // R2: input change is not seen before the next edge
    a_in = to_bcd(1); b_in = '0; carry_in = 1'b0;
    #1;
    expect_eq("R2", {carry_out, sum_out}, {1'b0, to_bcd(5555)});
    @(negedge clk);
    expect_eq("R2", {carry_out, sum_out}, {1'b0, 16'h0001});

    run_add("R3", 1, 0, 0);        // units nibble
    run_add("R3", 10, 0, 0);       // tens nibble
    run_add("R3", 1000, 0, 0);     // top nibble
    run_add("R4", 4, 5, 0);        // total 9, no carry
    run_add("R4", 0, 0, 0);
    run_add("R5", 5, 5, 0);        // total 10
    run_add("R5", 9, 9, 1);        // total 19
    run_add("R5", 7, 8, 0);        // total 15
    run_add("R6", 999, 1, 0);      // ripple into thousands
    run_add("R6", 9999, 1, 0);     // ripple to carry_out
    run_add("R6", 5000, 5000, 0);  // top pair exactly 10
    run_add("R6", 4999, 4000, 1);  // top pair 8 plus incoming carry
    run_add("R7", 0, 0, 1);
    run_add("R7", 9998, 0, 1);
    run_add("R8", 9999, 9999, 1);  // 19999
    run_add("R8", 9999, 9999, 0);

    for (int i = 0; i < 300; i++) begin
      run_add("R8", $urandom_range(LIMIT - 1, 0), $urandom_range(LIMIT - 1, 0), 1'($urandom_range(1, 0)));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule